// File: doc/BRIEF.md
# Dual-CPU FIFO Mailbox Port

This block passes byte messages between two processors that share one clock. Each processor has its own bus side. A side has a 2-bit port address, a chip select, read and write strobes, an 8-bit write bus, a registered 8-bit read bus and an interrupt output. Each direction has its own 8-bit by 16-entry FIFO. A side pushes into its send FIFO and pops from its receive FIFO, which is the other side's send FIFO.

Every control action comes from the kind of access (read or write) and the port it targets, not from register bits. One side can raise an interrupt flag on the other side. Only the side that receives a flag can clear it. Either side can empty its send FIFO, its receive FIFO or both. The normal usage is to load a message into the pipe and then raise the other side's interrupt.

An access lasts one clock cycle with chip select and a strobe high. Read data appears on the read bus after the clock edge that takes the read, and it holds until the next read.

Top module: `mbx_pipe`

## Requirements
- R1: Bytes that one side writes to port 0 come out of the other side's port 0 reads in the same order. Each direction holds 16 bytes and works independently of the other direction.
- R2: A read of port 1 returns the status byte of that side. Bit 0 is receive-not-empty, bit 1 is receive-full, bit 2 is send-empty, bit 3 is send-full, bit 4 is own-interrupt-pending and bit 5 is send-overflow. Bits 7:6 read as 0.
- R3: After reset, both interrupt outputs are 0, both read buses are 0x00 and both status bytes read 0x04.
- R4: A write to port 0 while the send FIFO is full is dropped and sets the sticky send-overflow bit. That bit stays set until that FIFO is reset by any of the reset actions.
- R5: A read of port 0 while the receive FIFO is empty returns 0x00 and leaves the FIFO unchanged.
- R6: A write to port 2 empties the side's send FIFO. A read of port 3 empties the side's receive FIFO. A write to port 3 empties both FIFOs. The value written has no effect.
- R7: If a push and a reset of the same FIFO happen in the same cycle, the reset wins and the FIFO ends up empty.
- R8: A write to port 1 sets the other side's interrupt, whatever the data value. A read of port 2 clears the reading side's own interrupt. A side cannot clear the other side's interrupt.
- R9: If a set and a clear of the same interrupt flag happen in the same cycle, the flag ends up set.
- R10: A read of port 2 or port 3 returns 0x00. An access with chip select low has no effect, and the read bus keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_addr_i | input | 2 | Side A port address |
| a_cs_i | input | 1 | Side A chip select |
| a_rd_i | input | 1 | Side A read strobe |
| a_wr_i | input | 1 | Side A write strobe |
| a_wdata_i | input | 8 | Side A write data |
| a_rdata_o | output | 8 | Side A registered read data |
| a_irq_o | output | 1 | Interrupt to side A |
| b_addr_i | input | 2 | Side B port address |
| b_cs_i | input | 1 | Side B chip select |
| b_rd_i | input | 1 | Side B read strobe |
| b_wr_i | input | 1 | Side B write strobe |
| b_wdata_i | input | 8 | Side B write data |
| b_rdata_o | output | 8 | Side B registered read data |
| b_irq_o | output | 1 | Interrupt to side B |

## Verification
The bench fills a FIFO to exactly 16 entries and then pushes one more byte. A design with an off-by-one depth would lose a stored byte or keep the extra one. A design whose overflow bit is not sticky would show the bit cleared after the FIFO drains.

The bench pops an empty FIFO and checks for 0x00 with no pointer movement. A design that moved its pointers here would return stale bytes on later pops.

In one cycle the bench pushes a byte while the other side resets that same FIFO. In another cycle it sets and clears the same interrupt flag. A design with the wrong priority would leave one byte in the FIFO, or would lose the notification.

The bench also writes with nonzero data to the command ports and makes accesses with chip select low. A design that decoded the data value, or that ignored chip select, would change the status byte or the read bus.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    PORT_DATA = 2'd0,
    PORT_CTRL = 2'd1,
    PORT_CLR  = 2'd2,
    PORT_RST  = 2'd3
  } port_e;

  typedef struct packed {
    logic push;
    logic pop;
    logic stat_rd;
    logic zero_rd;
    logic irq_set;
    logic irq_clr;
    logic rst_tx;
    logic rst_rx;
  } side_cmd_t;

  localparam int ST_RX_NE  = 0;
  localparam int ST_RX_FUL = 1;
  localparam int ST_TX_EMP = 2;
  localparam int ST_TX_FUL = 3;
  localparam int ST_IRQ    = 4;
  localparam int ST_OVF    = 5;
  localparam int ST_BITS   = 6;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
(
  input  logic [1:0] addr_i,
  input  logic       cs_i,
  input  logic       rd_i,
  input  logic       wr_i,
  output side_cmd_t  cmd_o
);
  logic rd, wr;
  port_e port;

  assign rd   = cs_i & rd_i;
  assign wr   = cs_i & wr_i;
  assign port = port_e'(addr_i);

  always_comb begin
    cmd_o = '0;
    unique case (port)
      PORT_DATA: begin
        cmd_o.pop  = rd;
        cmd_o.push = wr;
      end
      PORT_CTRL: begin
        cmd_o.stat_rd = rd;
        cmd_o.irq_set = wr;
      end
      PORT_CLR: begin
        cmd_o.irq_clr = rd;
        cmd_o.zero_rd = rd;
        cmd_o.rst_tx  = wr;
      end
      PORT_RST: begin
        cmd_o.rst_rx  = rd | wr;
        cmd_o.rst_tx  = wr;
        cmd_o.zero_rd = rd;
      end
      default: cmd_o = '0;
    endcase
  end
endmodule

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] head_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              ovf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count;
  logic              do_push, do_pop;

  assign empty_o = (count == '0);
  assign full_o  = (count == CNT_MAX);
  assign head_o  = empty_o ? '0 : mem[rd_ptr];
  assign do_push = push_i & ~full_o & ~clr_i;
  assign do_pop  = pop_i & ~empty_o & ~clr_i;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf_o  <= 1'b0;
    end else if (clr_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf_o  <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push_i && full_o) ovf_o <= 1'b1;
    end
  end

  a_r1_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= CNT_MAX);
  a_r4_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !clr_i) |=> ovf_o);
  a_r4_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !clr_i) |=> full_o);
  a_r5_empty_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i && !clr_i) |=> (empty_o && $stable(rd_ptr)));
  a_r7_clr_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (empty_o && !ovf_o));
endmodule

// File: rtl/mbx_irq_flag.sv
module mbx_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/mbx_pipe.sv
module mbx_pipe
  import mbx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        a_addr_i,
  input  logic              a_cs_i,
  input  logic              a_rd_i,
  input  logic              a_wr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  output logic [DATA_W-1:0] a_rdata_o,
  output logic              a_irq_o,
  input  logic [1:0]        b_addr_i,
  input  logic              b_cs_i,
  input  logic              b_rd_i,
  input  logic              b_wr_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  output logic [DATA_W-1:0] b_rdata_o,
  output logic              b_irq_o
);
  localparam int NSIDE = 2;

  logic [1:0]        s_addr  [NSIDE];
  logic              s_cs    [NSIDE];
  logic              s_rd    [NSIDE];
  logic              s_wr    [NSIDE];
  logic [DATA_W-1:0] s_wdata [NSIDE];
  logic [DATA_W-1:0] s_rdata [NSIDE];
  logic              s_irq   [NSIDE];
  side_cmd_t         cmd     [NSIDE];
  logic [DATA_W-1:0] tx_head [NSIDE];
  logic              tx_emp  [NSIDE];
  logic              tx_ful  [NSIDE];
  logic              tx_ovf  [NSIDE];

  assign s_addr[0] = a_addr_i;   assign s_addr[1] = b_addr_i;
  assign s_cs[0]   = a_cs_i;     assign s_cs[1]   = b_cs_i;
  assign s_rd[0]   = a_rd_i;     assign s_rd[1]   = b_rd_i;
  assign s_wr[0]   = a_wr_i;     assign s_wr[1]   = b_wr_i;
  assign s_wdata[0] = a_wdata_i; assign s_wdata[1] = b_wdata_i;
  assign a_rdata_o = s_rdata[0]; assign b_rdata_o = s_rdata[1];
  assign a_irq_o   = s_irq[0];   assign b_irq_o   = s_irq[1];

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    localparam int O = NSIDE - 1 - s;
    logic [ST_BITS-1:0] stat;

    mbx_port_decode u_dec (
      .addr_i (s_addr[s]),
      .cs_i   (s_cs[s]),
      .rd_i   (s_rd[s]),
      .wr_i   (s_wr[s]),
      .cmd_o  (cmd[s])
    );

    // FIFO s carries bytes from side s to side O
    mbx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (cmd[s].push),
      .wdata_i (s_wdata[s]),
      .pop_i   (cmd[O].pop),
      .clr_i   (cmd[s].rst_tx | cmd[O].rst_rx),
      .head_o  (tx_head[s]),
      .empty_o (tx_emp[s]),
      .full_o  (tx_ful[s]),
      .ovf_o   (tx_ovf[s])
    );

    mbx_irq_flag u_irq (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (cmd[O].irq_set),
      .clr_i  (cmd[s].irq_clr),
      .flag_o (s_irq[s])
    );

    always_comb begin
      stat = '0;
      stat[ST_RX_NE]  = ~tx_emp[O];
      stat[ST_RX_FUL] = tx_ful[O];
      stat[ST_TX_EMP] = tx_emp[s];
      stat[ST_TX_FUL] = tx_ful[s];
      stat[ST_IRQ]    = s_irq[s];
      stat[ST_OVF]    = tx_ovf[s];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              s_rdata[s] <= '0;
      else if (cmd[s].pop)      s_rdata[s] <= tx_head[O];
      else if (cmd[s].stat_rd)  s_rdata[s] <= {{(DATA_W-ST_BITS){1'b0}}, stat};
      else if (cmd[s].zero_rd)  s_rdata[s] <= '0;
    end

    a_r10_nocs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !s_cs[s] |=> $stable(s_rdata[s]));
    a_r2_rd_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({cmd[s].pop, cmd[s].stat_rd, cmd[s].zero_rd}));
  end
endmodule

// File: tb/sim_mbx_pipe.sv
module sim_mbx_pipe;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] a_addr = '0, b_addr = '0;
  logic       a_cs = 0, a_rd = 0, a_wr = 0, b_cs = 0, b_rd = 0, b_wr = 0;
  logic [7:0] a_wdata = '0, b_wdata = '0;
  logic [7:0] a_rdata, b_rdata;
  logic       a_irq, b_irq;
  int         n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  mbx_pipe u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .a_addr_i(a_addr), .a_cs_i(a_cs), .a_rd_i(a_rd), .a_wr_i(a_wr),
    .a_wdata_i(a_wdata), .a_rdata_o(a_rdata), .a_irq_o(a_irq),
    .b_addr_i(b_addr), .b_cs_i(b_cs), .b_rd_i(b_rd), .b_wr_i(b_wr),
    .b_wdata_i(b_wdata), .b_rdata_o(b_rdata), .b_irq_o(b_irq)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    a_cs = 0; a_rd = 0; a_wr = 0;
    b_cs = 0; b_rd = 0; b_wr = 0;
  endtask

  task automatic set_a(input logic [1:0] ad, input logic r, input logic w, input logic [7:0] d);
    a_addr = ad; a_cs = 1; a_rd = r; a_wr = w; a_wdata = d;
  endtask

  task automatic set_b(input logic [1:0] ad, input logic r, input logic w, input logic [7:0] d);
    b_addr = ad; b_cs = 1; b_rd = r; b_wr = w; b_wdata = d;
  endtask

  task automatic a_write(input logic [1:0] ad, input logic [7:0] d);
    set_a(ad, 0, 1, d); step();
  endtask
  task automatic b_write(input logic [1:0] ad, input logic [7:0] d);
    set_b(ad, 0, 1, d); step();
  endtask
  task automatic a_read(input logic [1:0] ad, input logic [7:0] exp, input string tag);
    set_a(ad, 1, 0, 8'h00); step(); chk(tag, a_rdata, exp);
  endtask
  task automatic b_read(input logic [1:0] ad, input logic [7:0] exp, input string tag);
    set_b(ad, 1, 0, 8'h00); step(); chk(tag, b_rdata, exp);
  endtask

  task automatic t_reset();
    chk("R3 a_irq", {7'd0, a_irq}, 8'h00);
    chk("R3 b_irq", {7'd0, b_irq}, 8'h00);
    chk("R3 a_rdata", a_rdata, 8'h00);
    chk("R3 b_rdata", b_rdata, 8'h00);
    a_read(2'd1, 8'h04, "R3 a status");
    b_read(2'd1, 8'h04, "R3 b status");
  endtask

  task automatic t_order();
    a_write(2'd0, 8'h11); a_write(2'd0, 8'h22); a_write(2'd0, 8'h33);
    b_write(2'd0, 8'hA5);
    a_read(2'd1, 8'h01, "R2 a status tx busy rx ne");
    b_read(2'd1, 8'h01, "R2 b status");
    b_read(2'd0, 8'h11, "R1 b pop0");
    b_read(2'd0, 8'h22, "R1 b pop1");
    b_read(2'd0, 8'h33, "R1 b pop2");
    b_read(2'd0, 8'h00, "R5 b pop empty");
    a_read(2'd0, 8'hA5, "R1 a pop");
    a_read(2'd0, 8'h00, "R5 a pop empty");
    b_read(2'd1, 8'h04, "R5 b status after empty pop");
  endtask

  task automatic t_full();
    for (int i = 0; i < 16; i++) a_write(2'd0, 8'(i * 7 + 1));
    a_read(2'd1, 8'h08, "R2 a status full");
    b_read(2'd1, 8'h07, "R2 b status rx full");
    a_write(2'd0, 8'hEE);
    a_read(2'd1, 8'h28, "R4 a status overflow");
    for (int i = 0; i < 16; i++) b_read(2'd0, 8'(i * 7 + 1), "R1 R4 b pop full");
    b_read(2'd0, 8'h00, "R4 extra byte dropped");
    a_read(2'd1, 8'h24, "R4 overflow sticky");
    a_write(2'd2, 8'hFF);
    a_read(2'd1, 8'h04, "R4 R6 send reset clears ovf");
  endtask

  task automatic t_resets();
    a_write(2'd0, 8'h01); a_write(2'd0, 8'h02);
    b_read(2'd3, 8'h00, "R10 port3 read zero");
    b_read(2'd1, 8'h04, "R6 b rx reset");
    a_read(2'd1, 8'h04, "R6 a tx emptied by peer");
    a_write(2'd0, 8'h03); b_write(2'd0, 8'h04);
    a_write(2'd3, 8'h5A);
    a_read(2'd1, 8'h04, "R6 both reset a");
    b_read(2'd1, 8'h04, "R6 both reset b");
    a_write(2'd0, 8'h09);
    a_write(2'd2, 8'h00);
    b_read(2'd1, 8'h04, "R6 port2 write resets send");
    a_addr = 2'd0; a_cs = 0; a_wr = 1; a_wdata = 8'h66; step();
    b_read(2'd1, 8'h04, "R10 no cs push ignored");
    a_read(2'd1, 8'h04, "R10 a status");
    a_addr = 2'd0; a_cs = 0; a_rd = 1; step();
    chk("R10 no cs read holds", a_rdata, 8'h04);
  endtask

  task automatic t_irq();
    b_write(2'd1, 8'h00);
    chk("R8 a_irq set", {7'd0, a_irq}, 8'h01);
    chk("R8 b_irq untouched", {7'd0, b_irq}, 8'h00);
    a_read(2'd1, 8'h14, "R2 irq status bit");
    b_read(2'd2, 8'h00, "R8 b cannot clear a");
    chk("R8 a_irq kept", {7'd0, a_irq}, 8'h01);
    a_read(2'd2, 8'h00, "R10 port2 read zero");
    chk("R8 a_irq cleared", {7'd0, a_irq}, 8'h00);
    a_write(2'd1, 8'hC3);
    chk("R8 b_irq set", {7'd0, b_irq}, 8'h01);
    b_read(2'd2, 8'h00, "R8 b port2");
    chk("R8 b_irq cleared", {7'd0, b_irq}, 8'h00);
  endtask

  task automatic t_race();
    a_write(2'd0, 8'h50);
    set_a(2'd0, 0, 1, 8'h77); set_b(2'd3, 1, 0, 8'h00); step();
    b_read(2'd1, 8'h04, "R7 reset beats push");
    b_read(2'd0, 8'h00, "R7 fifo empty");
    b_write(2'd1, 8'h00);
    set_b(2'd1, 0, 1, 8'h00); set_a(2'd2, 1, 0, 8'h00); step();
    chk("R9 set wins", {7'd0, a_irq}, 8'h01);
    a_read(2'd2, 8'h00, "R9 clear afterwards");
    chk("R9 cleared", {7'd0, a_irq}, 8'h00);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_full();
    t_resets();
    t_irq();
    t_race();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule